// File: doc/BRIEF.md
# Line-Gathering Write Buffer with Load Forwarding

This block sits between a core's store path and a memory write port. Stores that land in the same 16-byte line are gathered into a single buffered entry. Each entry keeps per-byte enables, so memory later receives one write that covers the whole line. Entries leave through a valid/ready drain port, oldest first.

Every store carries a non-gatherable attribute bit. A store with that bit set always takes a fresh entry of its own. Once allocated, that entry accepts no further stores. The attribute is the only thing that controls gathering: normal memory and device accesses merge in the same way.

Loads probe the buffer combinationally with a line address and a byte mask. If the buffer holds every requested byte, it reports a hit and returns the newest buffered value of each byte. If it holds only some of the requested bytes, it reports a partial hit instead.

Top module: `merging_store_buffer`

## Requirements
- R1: An accepted gatherable store whose line (address bits above bit 3) matches a buffered entry that is still open merges into that entry. The byte enables of the entry become the OR of the old enables and the store's strobes, and no new entry is taken.
- R2: A merge replaces exactly the bytes whose strobe bit b is set (data bits 8b+7..8b). All other bytes of the entry keep their earlier values.
- R3: An accepted non-gatherable store always allocates a new entry, even when an entry for the same line exists.
- R4: An entry allocated by a non-gatherable store is closed. A later gatherable store to the same line allocates a separate entry, and further gatherable stores merge into that newer entry.
- R5: While the buffer is not empty, the drain port is valid and presents the oldest entry: its line address with the low 4 bits zero, its data and its byte enables. Each accepted drain handshake removes exactly that one entry.
- R6: The store ready output is high whenever fewer than 4 entries are held, or whenever the offered store can merge. It is low only when all 4 entries are held and the store cannot merge.
- R7: A snoop reports a hit when every byte set in its mask is enabled in some entry of the snooped line. The returned data takes each byte from the newest such entry, and bytes that no entry covers read as zero.
- R8: When some entry matches the snooped line but not all requested bytes are covered, the partial flag is raised and hit is low. When no entry matches the line, both flags are low.
- R9: After reset the buffer is empty: drain valid is low and store ready is high.
- R10: An entry that completes a drain handshake in a given cycle takes no merge in that cycle. A gatherable store to its line in that cycle allocates a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store can be accepted this cycle |
| st_addr_i | input | 32 | Store byte address; bits 3:0 are ignored |
| st_data_i | input | 128 | Store data, byte b at bits 8b+7..8b |
| st_strb_i | input | 16 | Store byte strobes |
| st_nogather_i | input | 1 | Store targets a non-gatherable location |
| sn_addr_i | input | 32 | Snoop address; bits 3:0 are ignored |
| sn_mask_i | input | 16 | Bytes requested by the snoop |
| sn_hit_o | output | 1 | All requested bytes are buffered |
| sn_partial_o | output | 1 | Line is buffered but some requested byte is not |
| sn_data_o | output | 128 | Newest buffered bytes of the line |
| dr_valid_o | output | 1 | Oldest entry is presented for draining |
| dr_ready_i | input | 1 | Memory accepts the presented entry |
| dr_addr_o | output | 32 | Line address of the oldest entry |
| dr_data_o | output | 128 | Data of the oldest entry |
| dr_strb_o | output | 16 | Byte enables of the oldest entry |

## Verification
The assertions assume that every input has a known value once reset is released. They also assume the entry count is a power of two, so the ring pointers wrap without extra logic. The stimulus drives all inputs on the falling edge of every cycle. Addresses are drawn from only three lines, so merges, closed entries and full stalls happen often. The drain ready input alternates between long low stretches and random toggling, which keeps the buffer cycling between full and empty.

// File: rtl/msb_pkg.sv
package msb_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_DEPTH      = 4;
  localparam int unsigned DEF_LINE_BYTES = 16;
endpackage

// File: rtl/msb_lookup.sv
module msb_lookup #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 28,
  parameter int unsigned PTR_W = 2
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tag_i,
  input  logic [DEPTH-1:0]            vld_i,
  input  logic [DEPTH-1:0]            open_i,
  input  logic [DEPTH-1:0]            excl_i,
  input  logic [TAG_W-1:0]            st_tag_i,
  input  logic [TAG_W-1:0]            sn_tag_i,
  output logic                        mrg_hit_o,
  output logic [PTR_W-1:0]            mrg_idx_o,
  output logic [DEPTH-1:0]            sn_match_o
);
  logic [DEPTH-1:0] st_match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign st_match[i]   = vld_i[i] & open_i[i] & ~excl_i[i] & (tag_i[i] == st_tag_i);
    assign sn_match_o[i] = vld_i[i] & (tag_i[i] == sn_tag_i);
  end

  // at most one open entry per line exists, so any encoder order works
  always_comb begin
    mrg_hit_o = |st_match;
    mrg_idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (st_match[i]) mrg_idx_o = PTR_W'(i);
    end
  end
endmodule

// File: rtl/msb_forward.sv
module msb_forward #(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned PTR_W      = 2
) (
  input  logic [DEPTH-1:0][LINE_BYTES-1:0][7:0] data_i,
  input  logic [DEPTH-1:0][LINE_BYTES-1:0]      be_i,
  input  logic [DEPTH-1:0]                      match_i,
  input  logic [PTR_W-1:0]                      head_i,
  input  logic [LINE_BYTES-1:0]                 mask_i,
  output logic [LINE_BYTES-1:0][7:0]            data_o,
  output logic                                  hit_o,
  output logic                                  partial_o
);
  logic [LINE_BYTES-1:0] cov;
  logic [PTR_W-1:0]      idx;
  logic                  any;

  // walk oldest to newest so younger bytes overwrite older ones
  always_comb begin
    data_o = '0;
    cov    = '0;
    idx    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_i + PTR_W'(k);
      if (match_i[idx]) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (be_i[idx][b]) begin
            data_o[b] = data_i[idx][b];
            cov[b]    = 1'b1;
          end
        end
      end
    end
    any       = |match_i;
    hit_o     = any & ((mask_i & ~cov) == '0);
    partial_o = any & ~hit_o;
  end
endmodule

// File: rtl/merging_store_buffer.sv
module merging_store_buffer
  import msb_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DEPTH      = DEF_DEPTH,       // power of two
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [LINE_BYTES*8-1:0] st_data_i,
  input  logic [LINE_BYTES-1:0]   st_strb_i,
  input  logic                    st_nogather_i,
  input  logic [ADDR_W-1:0]       sn_addr_i,
  input  logic [LINE_BYTES-1:0]   sn_mask_i,
  output logic                    sn_hit_o,
  output logic                    sn_partial_o,
  output logic [LINE_BYTES*8-1:0] sn_data_o,
  output logic                    dr_valid_o,
  input  logic                    dr_ready_i,
  output logic [ADDR_W-1:0]       dr_addr_o,
  output logic [LINE_BYTES*8-1:0] dr_data_o,
  output logic [LINE_BYTES-1:0]   dr_strb_o
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][TAG_W-1:0]            tag_q;
  logic [DEPTH-1:0][LINE_BYTES-1:0][7:0]  data_q;
  logic [DEPTH-1:0][LINE_BYTES-1:0]       be_q;
  logic [DEPTH-1:0]                       vld_q, open_q;
  logic [PTR_W-1:0]                       head_q, tail_q;
  logic [CNT_W-1:0]                       cnt_q;

  logic [LINE_BYTES-1:0][7:0] st_bytes, sn_bytes;
  logic [DEPTH-1:0]           excl, sn_match;
  logic                       mrg_hit, can_merge, full, st_fire, push, pop;
  logic [PTR_W-1:0]           mrg_idx;

  assign st_bytes  = st_data_i;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign pop       = dr_valid_o & dr_ready_i;
  assign excl      = pop ? (DEPTH'(1) << head_q) : '0;
  assign can_merge = ~st_nogather_i & mrg_hit;
  assign st_ready_o = can_merge | ~full;
  assign st_fire   = st_valid_i & st_ready_o;
  assign push      = st_fire & ~can_merge;

  msb_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_lookup (
    .tag_i     (tag_q),
    .vld_i     (vld_q),
    .open_i    (open_q),
    .excl_i    (excl),
    .st_tag_i  (st_addr_i[ADDR_W-1:OFF_W]),
    .sn_tag_i  (sn_addr_i[ADDR_W-1:OFF_W]),
    .mrg_hit_o (mrg_hit),
    .mrg_idx_o (mrg_idx),
    .sn_match_o(sn_match)
  );

  msb_forward #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .PTR_W(PTR_W)) u_forward (
    .data_i   (data_q),
    .be_i     (be_q),
    .match_i  (sn_match),
    .head_i   (head_q),
    .mask_i   (sn_mask_i),
    .data_o   (sn_bytes),
    .hit_o    (sn_hit_o),
    .partial_o(sn_partial_o)
  );

  assign sn_data_o  = sn_bytes;
  assign dr_valid_o = (cnt_q != '0);
  assign dr_addr_o  = {tag_q[head_q], OFF_W'(0)};
  assign dr_data_o  = data_q[head_q];
  assign dr_strb_o  = be_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      data_q <= '0;
      be_q   <= '0;
      vld_q  <= '0;
      open_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (st_fire && can_merge) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (st_strb_i[b]) data_q[mrg_idx][b] <= st_bytes[b];
        end
        be_q[mrg_idx] <= be_q[mrg_idx] | st_strb_i;
      end
      if (push) begin
        tag_q[tail_q] <= st_addr_i[ADDR_W-1:OFF_W];
        for (int b = 0; b < LINE_BYTES; b++) begin
          data_q[tail_q][b] <= st_strb_i[b] ? st_bytes[b] : 8'h00;
        end
        be_q[tail_q]   <= st_strb_i;
        open_q[tail_q] <= ~st_nogather_i;
        vld_q[tail_q]  <= 1'b1;
        tail_q         <= tail_q + PTR_W'(1);
      end
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + PTR_W'(1);
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/msb_chk.sv
module msb_chk #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_valid_i,
  input logic              st_ready_o,
  input logic              st_nogather_i,
  input logic              dr_valid_o,
  input logic              dr_ready_i,
  input logic [ADDR_W-1:0] dr_addr_o,
  input logic              sn_hit_o,
  input logic              sn_partial_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              pop
);
  assert_ng_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_ready_o && st_nogather_i
      |=> cnt_q == $past(cnt_q) + CNT_W'(1) - CNT_W'($past(pop)));

  assert_full_merge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_ready_o && cnt_q == CNT_W'(DEPTH) && !pop |=> cnt_q == CNT_W'(DEPTH));

  assert_space_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(DEPTH) |-> st_ready_o);

  assert_drain_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_valid_o && !dr_ready_i |=> dr_valid_o && $stable(dr_addr_o));

  assert_snoop_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sn_hit_o && sn_partial_o));
endmodule

bind merging_store_buffer msb_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .st_valid_i   (st_valid_i),
  .st_ready_o   (st_ready_o),
  .st_nogather_i(st_nogather_i),
  .dr_valid_o   (dr_valid_o),
  .dr_ready_i   (dr_ready_i),
  .dr_addr_o    (dr_addr_o),
  .sn_hit_o     (sn_hit_o),
  .sn_partial_o (sn_partial_o),
  .cnt_q        (cnt_q),
  .pop          (pop)
);

// File: tb/merging_store_buffer_tb.sv
module merging_store_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         st_valid_i = 1'b0;
  logic         st_ready_o;
  logic [31:0]  st_addr_i = '0;
  logic [127:0] st_data_i = '0;
  logic [15:0]  st_strb_i = '0;
  logic         st_nogather_i = 1'b0;
  logic [31:0]  sn_addr_i = '0;
  logic [15:0]  sn_mask_i = '0;
  logic         sn_hit_o, sn_partial_o;
  logic [127:0] sn_data_o;
  logic         dr_valid_o;
  logic         dr_ready_i = 1'b0;
  logic [31:0]  dr_addr_o;
  logic [127:0] dr_data_o;
  logic [15:0]  dr_strb_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [27:0]  m_tag [DEPTH];
  logic [127:0] m_data[DEPTH];
  logic [15:0]  m_be  [DEPTH];
  bit           m_open[DEPTH];
  int           m_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  merging_store_buffer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o), .st_addr_i(st_addr_i),
    .st_data_i(st_data_i), .st_strb_i(st_strb_i), .st_nogather_i(st_nogather_i),
    .sn_addr_i(sn_addr_i), .sn_mask_i(sn_mask_i), .sn_hit_o(sn_hit_o),
    .sn_partial_o(sn_partial_o), .sn_data_o(sn_data_o),
    .dr_valid_o(dr_valid_o), .dr_ready_i(dr_ready_i), .dr_addr_o(dr_addr_o),
    .dr_data_o(dr_data_o), .dr_strb_o(dr_strb_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp,
                     input string what, input string tg);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s [%s]: actual %h expected %h", req, what, tg, act, exp);
    end
  endtask

  task automatic step(input bit sv, input logic [31:0] a, input logic [127:0] d,
                      input logic [15:0] s, input bit ng, input bit rdy,
                      input logic [31:0] sa, input logic [15:0] sm, input string tg);
    int midx;
    bit pop_e, rdy_e, any, hit_e;
    logic [127:0] fd;
    logic [15:0] cov;
    @(negedge clk_i);
    st_valid_i = sv; st_addr_i = a; st_data_i = d; st_strb_i = s; st_nogather_i = ng;
    dr_ready_i = rdy; sn_addr_i = sa; sn_mask_i = sm;
    #1;
    pop_e = (m_cnt > 0) && rdy;
    midx = -1;
    if (!ng) begin
      for (int k = 0; k < m_cnt; k++)
        if (!(k == 0 && pop_e) && m_open[k] && m_tag[k] == a[31:4]) midx = k;
    end
    rdy_e = (midx >= 0) || (m_cnt < DEPTH);
    chk("R6", 128'(st_ready_o), 128'(rdy_e), "st_ready", tg);
    chk("R5", 128'(dr_valid_o), 128'(m_cnt > 0), "dr_valid", tg);
    if (m_cnt > 0) begin
      chk("R5", 128'(dr_addr_o), 128'({m_tag[0], 4'h0}), "dr_addr", tg);
      chk("R2", dr_data_o, m_data[0], "dr_data", tg);
      chk("R1", 128'(dr_strb_o), 128'(m_be[0]), "dr_strb", tg);
    end
    fd = '0; cov = '0; any = 0;
    for (int k = 0; k < m_cnt; k++) begin
      if (m_tag[k] == sa[31:4]) begin
        any = 1;
        for (int b = 0; b < 16; b++)
          if (m_be[k][b]) begin fd[b*8 +: 8] = m_data[k][b*8 +: 8]; cov[b] = 1'b1; end
      end
    end
    hit_e = any && ((sm & ~cov) == '0);
    chk("R7", 128'(sn_hit_o), 128'(hit_e), "sn_hit", tg);
    chk("R8", 128'(sn_partial_o), 128'(any && !hit_e), "sn_partial", tg);
    if (hit_e) chk("R7", sn_data_o, fd, "sn_data", tg);
    @(posedge clk_i);
    if (pop_e) begin
      for (int k = 0; k < DEPTH-1; k++) begin
        m_tag[k] = m_tag[k+1]; m_data[k] = m_data[k+1];
        m_be[k] = m_be[k+1]; m_open[k] = m_open[k+1];
      end
      m_cnt--;
      if (midx > 0) midx--;
    end
    if (sv && rdy_e) begin
      if (midx >= 0) begin
        for (int b = 0; b < 16; b++)
          if (s[b]) m_data[midx][b*8 +: 8] = d[b*8 +: 8];
        m_be[midx] = m_be[midx] | s;
      end else begin
        m_tag[m_cnt] = a[31:4];
        m_be[m_cnt] = s;
        m_open[m_cnt] = !ng;
        for (int b = 0; b < 16; b++)
          m_data[m_cnt][b*8 +: 8] = s[b] ? d[b*8 +: 8] : 8'h00;
        m_cnt++;
      end
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 32'h1000_0000, 16'h0001, "flush");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  localparam logic [31:0] LA = 32'h1000_0000;
  localparam logic [31:0] LB = 32'h1000_0010;
  localparam logic [31:0] LC = 32'h1000_0020;

  initial begin
    void'($urandom(32'h5eed_0001));
    for (int k = 0; k < DEPTH; k++) begin
      m_tag[k] = '0; m_data[k] = '0; m_be[k] = '0; m_open[k] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, LA, 16'hffff, "R9 reset empty");

    // non-gatherable stores never merge
    step(1, LA, {4{32'haaaa_aaaa}}, 16'h000f, 1, 0, LA, 16'h000f, "R3 first");
    step(1, LA, {4{32'hbbbb_bbbb}}, 16'h000f, 1, 0, LA, 16'h000f, "R3 second");
    step(0, 0, 0, 0, 0, 0, LA, 16'h001f, "R3 snoop partial");
    flush();

    // closed entry, then a fresh gatherable entry that merges
    step(1, LB, {4{32'h1111_1111}}, 16'h00f0, 1, 0, LB, 16'h00f0, "R4 ng");
    step(1, LB, {4{32'h2222_2222}}, 16'h0f00, 0, 0, LB, 16'h0f00, "R4 gather");
    step(1, LB, {4{32'h3333_3333}}, 16'hf000, 0, 0, LB, 16'hfff0, "R4 merge");
    step(0, 0, 0, 0, 0, 0, LB, 16'hff00, "R4 snoop");
    flush();

    // full with nothing open: stall
    for (int i = 0; i < 4; i++)
      step(1, LC, {4{$urandom()}}, 16'h0003, 1, 0, LC, 16'h0003, "R6 fill");
    step(1, LC, {4{32'h4444_4444}}, 16'h0003, 0, 0, LC, 16'h0003, "R6 full stall");
    flush();

    // full but the offered store merges
    for (int i = 0; i < 3; i++)
      step(1, LB, {4{$urandom()}}, 16'h0001, 1, 0, LB, 16'h0001, "R6 fill");
    step(1, LA, {4{32'h5555_5555}}, 16'h00ff, 0, 0, LA, 16'h00ff, "R6 open");
    step(1, LA, {4{32'h6666_6666}}, 16'h0ff0, 0, 0, LA, 16'h0fff, "R6 merge when full");
    step(0, 0, 0, 0, 0, 0, LA, 16'h0fff, "R2 later wins");
    flush();

    // store to head's line in the drain cycle
    step(1, LA, {4{32'h7777_7777}}, 16'h000f, 0, 0, LA, 16'h000f, "R10 alloc");
    step(1, LA, {4{32'h8888_8888}}, 16'h00f0, 0, 1, LA, 16'h00ff, "R10 drain+store");
    step(0, 0, 0, 0, 0, 0, LA, 16'h00ff, "R10 after");
    flush();

    for (int i = 0; i < 4000; i++) begin
      bit rdy;
      logic [15:0] sm;
      rdy = ((i / 200) % 2 == 1) ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 1) == 1);
      sm = ($urandom_range(0, 1) == 1) ? (16'h0001 << $urandom_range(0, 15))
                                       : 16'($urandom_range(1, 16'hffff));
      step($urandom_range(0, 3) != 0,
           LA + 32'($urandom_range(0, 2) << 4) + 32'($urandom_range(0, 15)),
           {$urandom(), $urandom(), $urandom(), $urandom()},
           16'($urandom_range(1, 16'hffff)),
           $urandom_range(0, 4) == 0, rdy,
           LA + 32'($urandom_range(0, 2) << 4), sm, "random R1 R2 R5 R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule